// File: doc/BRIEF.md
# Link-Loss Recovery Reset Controller

This block brings a stuck serial link back by resetting the datapath logic when the link stays down. A watchdog counts timebase ticks while the link-up input is low and no loopback is active. When the interval runs out, the block sends one datapath reset request and starts the count again. It keeps doing this once per interval until the link returns. A link that is up, or an active loopback, holds the count at zero, so the watchdog never fires in either condition.

Software can also ask for the same reset by setting a self-clearing bit in a small command register. The block acts on that write only when a loopback change or a mode-register change is pending, because an unconditional reset on every reconfiguration would glitch a healthy link. The reset leaves configuration alone: the mode register keeps its contents.

Only one reset is in flight at a time. While a reset runs, the block samples the done input at fixed poll points, up to a bounded number of polls. If completion is never seen, the block withdraws the request and sets a sticky timeout flag. Software clears that flag by writing 1 to it.

Top module: `linkfix_reset_ctrl`

## Requirements
- R1: After the synchronous reset, dp_rst_req and rst_timeout are 0, the command register (address 0) reads 0, the mode register (address 1) reads 0 and the watchdog count starts from zero.
- R2: With link_up and loopback_on both low for INTERVAL_TICKS consecutive tick_pulse ticks, one reset request starts. Another starts every further INTERVAL_TICKS ticks while the link stays down.
- R3: While link_up or loopback_on is high, the watchdog count is held at zero and no watchdog reset is issued. A short return of the link restarts the full interval.
- R4: A write with bit 14 set to the command register starts a reset only if a change is pending. A change is pending when loopback_on has changed, or the mode register has been written with a value different from its current one, since the last reset started. Otherwise the write is ignored.
- R5: Command bit 14 reads 1 and dp_rst_req is high for as long as a reset is in progress. Both return to 0 once dp_rst_done is seen at a poll point.
- R6: dp_rst_done is sampled once every POLL_CYC cycles, at most MAX_POLLS times. If it is never seen, dp_rst_req drops and the timeout flag is set (rst_timeout output, command bit 1).
- R7: The timeout flag stays set until a write to the command register with bit 1 set. A command write with bit 1 clear leaves the flag set.
- R8: A watchdog expiry or command write that arrives while a reset is in flight is absorbed into that reset and not queued.
- R9: A reset, whether it completes or times out, leaves the mode register contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_pulse | input | 1 | One-cycle timebase tick for the watchdog |
| link_up | input | 1 | High while the link reports up |
| loopback_on | input | 1 | High while any loopback mode is active |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on reg_rdata the next cycle |
| reg_addr | input | ADDR_W | Register address (0 command, 1 mode) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| dp_rst_req | output | 1 | Datapath logic-reset request, high while a reset is in flight |
| dp_rst_done | input | 1 | Datapath reports reset complete |
| rst_timeout | output | 1 | Sticky flag: the last reset did not complete in time |

## Verification
The bench counts request edges across several watchdog intervals. A timer that failed to restart after firing, or that fired early, would show a missing or extra request. It holds the link briefly up, or puts loopback on, in the middle of a down period: a design that only paused the count instead of clearing it would still reset. Command writes are issued with no pending change, with a mode write of the same value, and during a reset in flight. A design without change gating, or one that queued requests, would produce a second request edge. The bench also lets a reset run out without completion and checks that the flag survives a write that does not clear it. It then reads the mode register to show that neither a completed nor a timed-out reset changed it.

// File: rtl/linkfix_pkg.sv
// Shared constants for the link-loss recovery reset controller.
// Assumes a 16-bit register file with two decoded addresses.
package linkfix_pkg;
    localparam int CMD_ADDR    = 0;   // command register
    localparam int MODE_ADDR   = 1;   // configuration (mode) register
    localparam int CMD_RST_BIT = 14;  // self-clearing logic-reset bit
    localparam int CMD_TO_BIT  = 1;   // sticky timeout flag, write 1 to clear
endpackage

// File: rtl/linkfix_wdog.sv
// Link-down watchdog: counts ticks while the link is down outside loopback
// and pulses fire for one cycle each time INTERVAL_TICKS ticks have elapsed.
// Assumes link_up, loopback_on and tick are synchronous to clk.
module linkfix_wdog #(
    parameter int INTERVAL_TICKS = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic link_up,
    input  logic loopback_on,
    output logic fire
);
    localparam int CNT_W = (INTERVAL_TICKS > 1) ? $clog2(INTERVAL_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL_TICKS - 1);

    logic [CNT_W-1:0] cnt;

    // Interval counter: cleared by link-up or loopback, wraps on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            fire <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (link_up || loopback_on) begin
                cnt <= '0;
            end else if (tick) begin
                if (cnt == LAST) begin
                    cnt  <= '0;
                    fire <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R3: no expiry may follow a cycle with the link up or loopback active
    a_r3_no_fire_when_held: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up || loopback_on) |=> !fire);

endmodule

// File: rtl/linkfix_rstseq.sv
// Reset sequencer: accepts one trigger at a time, holds busy (the request)
// and polls done every POLL_CYC cycles, at most MAX_POLLS times.
// Triggers that arrive while busy are dropped.
module linkfix_rstseq #(
    parameter int POLL_CYC  = 125,
    parameter int MAX_POLLS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wd_fire,
    input  logic cmd_start,
    input  logic done,
    output logic busy,
    output logic started,
    output logic timeout_pulse
);
    localparam int CYC_W  = $clog2(POLL_CYC + 1);
    localparam int POLL_W = $clog2(MAX_POLLS + 1);
    localparam logic [CYC_W-1:0]  CYC_LAST  = CYC_W'(POLL_CYC - 1);
    localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(MAX_POLLS - 1);

    logic              trig;
    logic [CYC_W-1:0]  cyc;
    logic [POLL_W-1:0] polls;

    // Merge the two request sources; accepted only when idle.
    always_comb begin
        trig    = wd_fire || cmd_start;
        started = trig && !busy;
    end

    // Busy window, poll spacing and poll count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy          <= 1'b0;
            cyc           <= '0;
            polls         <= '0;
            timeout_pulse <= 1'b0;
        end else begin
            timeout_pulse <= 1'b0;
            if (!busy) begin
                if (trig) begin
                    busy  <= 1'b1;
                    cyc   <= '0;
                    polls <= '0;
                end
            end else if (cyc == CYC_LAST) begin
                cyc <= '0;
                if (done) begin
                    busy <= 1'b0;
                end else if (polls == POLL_LAST) begin
                    busy          <= 1'b0;
                    timeout_pulse <= 1'b1;
                end else begin
                    polls <= polls + 1'b1;
                end
            end else begin
                cyc <= cyc + 1'b1;
            end
        end
    end

    // R6: the poll count never reaches the poll limit
    a_r6_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
        polls < POLL_W'(MAX_POLLS));

    // R6: a timeout is only reported at the end of a busy window
    a_r6_timeout_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |-> (!busy && $past(busy)));

    // R8: a trigger during a reset does not restart its poll sequence
    a_r8_absorbed: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && trig) |=> (!busy || polls >= $past(polls)));

endmodule

// File: rtl/linkfix_regs.sv
// Register file: command register (reset bit, sticky timeout flag) and
// mode register. Tracks whether a configuration change is pending and
// gates software reset requests on it. Read data is registered.
module linkfix_regs
    import linkfix_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              loopback_on,
    input  logic              busy,
    input  logic              started,
    input  logic              timeout_pulse,
    output logic              cmd_start,
    output logic              timeout_flag
);
    logic              prev_loop;
    logic              dirty;
    logic [DATA_W-1:0] mode_q;
    logic              wr_cmd;
    logic              wr_mode;
    logic              change_seen;

    // Decode writes and the software reset request.
    always_comb begin
        wr_cmd      = reg_wr && (reg_addr == ADDR_W'(CMD_ADDR));
        wr_mode     = reg_wr && (reg_addr == ADDR_W'(MODE_ADDR));
        change_seen = (loopback_on != prev_loop) || (wr_mode && (reg_wdata != mode_q));
        cmd_start   = wr_cmd && reg_wdata[CMD_RST_BIT] && dirty && !busy;
    end

    // Pending-change flag: set by a change, consumed when a reset starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_loop <= 1'b0;
            dirty     <= 1'b0;
        end else begin
            prev_loop <= loopback_on;
            if (change_seen)  dirty <= 1'b1;
            else if (started) dirty <= 1'b0;
        end
    end

    // Mode register: written only by software, never by a reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (wr_mode) mode_q <= reg_wdata;
    end

    // Sticky timeout flag, write-one-to-clear; a new timeout wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                                timeout_flag <= 1'b0;
        else if (timeout_pulse)                    timeout_flag <= 1'b1;
        else if (wr_cmd && reg_wdata[CMD_TO_BIT])  timeout_flag <= 1'b0;
    end

    // Registered read mux.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= '0;
            if (reg_addr == ADDR_W'(CMD_ADDR)) begin
                reg_rdata[CMD_RST_BIT] <= busy;
                reg_rdata[CMD_TO_BIT]  <= timeout_flag;
            end else if (reg_addr == ADDR_W'(MODE_ADDR)) begin
                reg_rdata <= mode_q;
            end
        end
    end

    // R7: the flag only drops on a clearing write
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_flag && !(wr_cmd && reg_wdata[CMD_TO_BIT])) |=> timeout_flag);

    // R9: the mode register changes only through a mode write
    a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mode |=> $stable(mode_q));

endmodule

// File: rtl/linkfix_reset_ctrl.sv
// Top level of the link-loss recovery reset controller: watchdog,
// register file and reset sequencer. dp_rst_req is high for the whole
// reset window; dp_rst_done is expected to stay high until it drops.
module linkfix_reset_ctrl #(
    parameter int INTERVAL_TICKS = 5000,
    parameter int POLL_CYC       = 125,
    parameter int MAX_POLLS      = 50,
    parameter int DATA_W         = 16,
    parameter int ADDR_W         = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_pulse,
    input  logic              link_up,
    input  logic              loopback_on,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              dp_rst_req,
    input  logic              dp_rst_done,
    output logic              rst_timeout
);
    logic wd_fire;
    logic cmd_start;
    logic busy;
    logic started;
    logic timeout_pulse;

    linkfix_wdog #(.INTERVAL_TICKS(INTERVAL_TICKS)) u_wdog (
        .clk(clk), .rst_n(rst_n), .tick(tick_pulse), .link_up(link_up),
        .loopback_on(loopback_on), .fire(wd_fire)
    );

    linkfix_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .loopback_on(loopback_on), .busy(busy), .started(started),
        .timeout_pulse(timeout_pulse), .cmd_start(cmd_start),
        .timeout_flag(rst_timeout)
    );

    linkfix_rstseq #(.POLL_CYC(POLL_CYC), .MAX_POLLS(MAX_POLLS)) u_seq (
        .clk(clk), .rst_n(rst_n), .wd_fire(wd_fire), .cmd_start(cmd_start),
        .done(dp_rst_done), .busy(busy), .started(started),
        .timeout_pulse(timeout_pulse)
    );

    // Request output follows the sequencer's busy window.
    always_comb dp_rst_req = busy;

endmodule

// File: tb/sim_linkfix_reset_ctrl.sv
// Directed bench for linkfix_reset_ctrl with short interval and poll values.
module sim_linkfix_reset_ctrl;
    localparam int INTERVAL = 6;
    localparam int POLLC    = 4;
    localparam int NPOLL    = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_pulse = 1'b0;
    logic        link_up = 1'b1;
    logic        loopback_on = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        dp_rst_req;
    logic        dp_rst_done = 1'b0;
    logic        rst_timeout;

    int errors = 0;
    int checks = 0;
    int rises  = 0;
    logic req_prev = 1'b0;
    logic auto_done = 1'b1;
    int done_cnt = 0;
    int tick_div = 0;
    bit finished = 0;

    linkfix_reset_ctrl #(.INTERVAL_TICKS(INTERVAL), .POLL_CYC(POLLC),
                         .MAX_POLLS(NPOLL), .DATA_W(16), .ADDR_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_pulse(tick_pulse), .link_up(link_up),
        .loopback_on(loopback_on), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dp_rst_req(dp_rst_req), .dp_rst_done(dp_rst_done), .rst_timeout(rst_timeout)
    );

    always #4 clk = ~clk;

    // Timebase tick every 5 cycles, driven off the falling edge.
    always @(negedge clk) begin
        tick_div   = (tick_div == 4) ? 0 : tick_div + 1;
        tick_pulse = (tick_div == 0);
    end

    // Datapath model: done three cycles after the request, held until it drops.
    always @(negedge clk) begin
        if (auto_done && dp_rst_req) done_cnt = done_cnt + 1;
        else done_cnt = 0;
        dp_rst_done = (done_cnt >= 3);
    end

    // Count request rising edges.
    always @(posedge clk) begin
        if (dp_rst_req && !req_prev) rises = rises + 1;
        req_prev = dp_rst_req;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        check("R1 req after reset", dp_rst_req, 0);
        check("R1 timeout after reset", rst_timeout, 0);
        rd(4'd0, d); check("R1 cmd reads 0", d, 0);
        rd(4'd1, d); check("R1 mode reads 0", d, 0);
    endtask

    task automatic t_watchdog_repeat();
        int base;
        auto_done = 1'b1;
        base = rises;
        link_up = 1'b0;
        wait_cyc(20);
        check("R2 no early request", rises - base, 0);
        wait_cyc(85);
        check("R2 three requests over 3.5 intervals", rises - base, 3);
        link_up = 1'b1;
        wait_cyc(10);
    endtask

    task automatic t_hold_off();
        int base;
        base = rises;
        wait_cyc(200);
        check("R3 link up gives no reset", rises - base, 0);
        loopback_on = 1'b1;
        link_up = 1'b0;
        wait_cyc(200);
        check("R3 loopback gives no reset", rises - base, 0);
        link_up = 1'b1;
        loopback_on = 1'b0;
        wait_cyc(2);
        for (int k = 0; k < 8; k++) begin
            link_up = 1'b0;
            wait_cyc(20);
            link_up = 1'b1;
            wait_cyc(1);
        end
        check("R3 brief link-up restarts interval", rises - base, 0);
    endtask

    task automatic t_cmd_gating();
        int base;
        logic [15:0] d;
        auto_done = 1'b1;
        base = rises;
        wr(4'd1, 16'h00A5);
        wr(4'd0, 16'h4000);
        wait_cyc(30);
        check("R4 pending change accepted", rises - base, 1);
        rd(4'd0, d); check("R5 bit14 cleared after completion", d, 0);
        wr(4'd0, 16'h4000);
        wait_cyc(30);
        check("R4 no pending change ignored", rises - base, 1);
        rd(4'd0, d); check("R4 ignored write leaves bit14 at 0", d, 0);
        wr(4'd1, 16'h00A5);
        wr(4'd0, 16'h4000);
        wait_cyc(30);
        check("R4 same-value mode write is not a change", rises - base, 1);
    endtask

    task automatic t_busy_absorb();
        int base;
        logic [15:0] d;
        auto_done = 1'b0;
        base = rises;
        wr(4'd1, 16'h1234);
        wr(4'd0, 16'h4000);
        wait_cyc(2);
        rd(4'd0, d); check("R5 bit14 reads 1 while busy", d, 16'h4000);
        check("R5 request held while busy", dp_rst_req, 1);
        wr(4'd1, 16'h5678);
        wr(4'd0, 16'h4000);
        auto_done = 1'b1;
        wait_cyc(40);
        check("R8 absorbed request not queued", rises - base, 1);
        check("R5 request dropped after done", dp_rst_req, 0);
        rd(4'd1, d); check("R9 mode kept after reset", d, 16'h5678);
    endtask

    task automatic t_timeout();
        logic [15:0] d;
        auto_done = 1'b0;
        wr(4'd1, 16'h0F0F);
        wr(4'd0, 16'h4000);
        wait_cyc(100);
        check("R6 no timeout before poll limit", rst_timeout, 0);
        check("R6 request still out", dp_rst_req, 1);
        wait_cyc(150);
        check("R6 timeout raised", rst_timeout, 1);
        check("R6 request withdrawn", dp_rst_req, 0);
        rd(4'd0, d); check("R6 cmd shows timeout only", d, 16'h0002);
        wr(4'd0, 16'h0000);
        rd(4'd0, d); check("R7 flag survives non-clearing write", d, 16'h0002);
        check("R7 output still set", rst_timeout, 1);
        wr(4'd0, 16'h0002);
        rd(4'd0, d); check("R7 flag cleared by write 1", d, 0);
        check("R7 output cleared", rst_timeout, 0);
        rd(4'd1, d); check("R9 mode kept after timeout", d, 16'h0F0F);
        auto_done = 1'b1;
    endtask

    initial begin
        t_reset();
        t_watchdog_repeat();
        t_hold_off();
        t_cmd_gating();
        t_busy_absorb();
        t_timeout();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule